// File: doc/BRIEF.md
# Serial Register Access Slave with Selectable Bit Order

This block lets an external serial master read and write a register space addressed by 13 bits, holding 8-bit registers, over a four-wire synchronous serial link. The system clock oversamples the serial clock, MOSI and chip select through two-flop synchronizers. All decoding runs in the system clock domain. Clock polarity, clock phase and bit order are static configuration pins. They may change only while chip select is high.

Every transaction begins with a 16-slot control word and continues with 8-slot data bytes. Slot 0 carries the direction flag and slot 15 carries the burst flag. The 14 slots between them carry a field whose low 13 bits are the address and whose top bit is reserved. The bit-order input reverses the address field and the data bytes only. The two flags keep their slots in both orders.

The block issues single-cycle read and write strobes with address and write data. It expects the read data combinationally on `reg_rdata` in the cycle of the read strobe. The serial master cannot be stalled, so the register side has no back-pressure. A register port that cannot take a strobe in its cycle must buffer it itself. MISO has a separate output enable that goes low as soon as chip select rises.

Top module: `spi_reg_slave`

## Requirements
- R1: With `cfg_cpol`=0 the clock idles low, and with 1 it idles high. With `cfg_cpha`=0 MOSI is sampled on the first (leading) edge of each slot, and with 1 on the second (trailing) edge. This holds in all four combinations.
- R2: In every clock mode, MISO holds each read-data bit stable over the edge on which the master samples it.
- R3: With `cfg_swap`=0 the address field and the data bytes travel least significant bit first. With `cfg_swap`=1 they travel most significant bit first.
- R4: Control-word slot 0 is the direction flag (1 = read, 0 = write) and slot 15 is the burst flag, whatever `cfg_swap` is. Slots 1 to 14 form a 14-bit field. Address = field[12:0]. field[13] is reserved and has no effect on the access.
- R5: A write produces one `reg_wr_stb` pulse, one cycle long, with `reg_addr` and the byte in `reg_wdata`, after the last bit of each accepted data byte.
- R6: A read produces one `reg_rd_stb` pulse after the control word. `reg_rdata` is captured in that cycle and shifted out in the byte slot that follows.
- R7: With burst set, each further byte accesses the next address (plus one, wrapping from 8191 to 0). A burst read strobes the next address at the end of every byte.
- R8: Without burst, only the first data byte is accessed. Later bytes give no strobes, and a read returns zeros in them.
- R9: While chip select is high `spi_miso_oe` is 0. A transaction cut off mid-byte gives no strobe, and the next transaction starts from control-word slot 0.
- R10: `reg_rd_stb` and `reg_wr_stb` are never high together, and neither is high once chip select has been high for more than two cycles.
- R11: After reset both strobes and `spi_miso_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_swap | input | 1 | 0: address/data LSB first, 1: MSB first |
| spi_sclk | input | 1 | Serial clock from master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| reg_rd_stb | output | 1 | Register read strobe, one cycle |
| reg_wr_stb | output | 1 | Register write strobe, one cycle |
| reg_addr | output | 13 | Register address for the strobes |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid in the read-strobe cycle |

## Verification
The bench acts as the master in all four clock modes and both bit orders, under seeded random traffic and directed cases. The chosen mode catches a design that samples on the wrong edge, because every address and byte then arrives shifted by one slot. A reversed bit order that also moved the flag slots turns writes into reads. A burst started at address 8191 must wrap to 0, and an adder that carries into the reserved bit would strobe the wrong register. A non-burst read must return zero bytes after the first, which a stale shift register would not. A transfer cut off after three data bits must give no write, and the next transfer must decode correctly, which exposes a bit counter that survives chip-select release.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic {PH_CTRL = 1'b0, PH_DATA = 1'b1} spi_phase_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic mosi,
  input  logic cs_n,
  input  logic cpol,
  input  logic cpha,
  output logic sample_pulse,
  output logic mosi_s,
  output logic cs_act
);
  logic [SYNC_STAGES-1:0] sclk_q, mosi_q, csn_q;
  logic sclk_prev, rise, fall, lead_edge, trail_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= '0;
      mosi_q    <= '0;
      csn_q     <= '1;
      sclk_prev <= 1'b0;
    end else begin
      sclk_q    <= {sclk_q[SYNC_STAGES-2:0], sclk};
      mosi_q    <= {mosi_q[SYNC_STAGES-2:0], mosi};
      csn_q     <= {csn_q[SYNC_STAGES-2:0], cs_n};
      sclk_prev <= sclk_q[SYNC_STAGES-1];
    end
  end

  assign rise       = sclk_q[SYNC_STAGES-1] & ~sclk_prev;
  assign fall       = ~sclk_q[SYNC_STAGES-1] & sclk_prev;
  assign lead_edge  = cpol ? fall : rise;
  assign trail_edge = cpol ? rise : fall;
  assign cs_act     = ~csn_q[SYNC_STAGES-1];
  assign mosi_s     = mosi_q[SYNC_STAGES-1];
  assign sample_pulse = cs_act & (cpha ? trail_edge : lead_edge);

  // R1: edges pass the synchronizer as isolated single-cycle events
  p_edge_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pulse |=> !sample_pulse);
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_pulse,
  input  logic              mosi_s,
  input  logic              cs_act,
  input  logic              swap,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [$clog2(DATA_W)-1:0] data_cnt,
  output logic              data_phase,
  output logic              byte_end
);
  localparam int FIELD_W = ADDR_W + 1;
  localparam int CTRL_W  = FIELD_W + 2;
  localparam int CNT_W   = $clog2(CTRL_W);
  localparam int DCNT_W  = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(CTRL_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  spi_phase_e        phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CTRL_W-1:0] ctrl_sr;
  logic [DATA_W-1:0] data_sr;
  logic              ctrl_done_q, byte_done_q;
  logic              is_read, is_burst, got_byte;
  logic [ADDR_W-1:0] addr_q;
  logic [FIELD_W-1:0] field_dec;
  logic [DATA_W-1:0]  data_dec;

  // bit-order swap touches only the field between the two flag slots
  for (genvar i = 0; i < FIELD_W; i++) begin : g_field
    assign field_dec[i] = swap ? ctrl_sr[FIELD_W - i] : ctrl_sr[1 + i];
  end
  for (genvar i = 0; i < DATA_W; i++) begin : g_data
    assign data_dec[i] = swap ? data_sr[DATA_W - 1 - i] : data_sr[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_CTRL;
      bit_cnt     <= '0;
      ctrl_sr     <= '0;
      data_sr     <= '0;
      ctrl_done_q <= 1'b0;
      byte_done_q <= 1'b0;
    end else if (!cs_act) begin
      phase       <= PH_CTRL;
      bit_cnt     <= '0;
      ctrl_done_q <= 1'b0;
      byte_done_q <= 1'b0;
    end else begin
      ctrl_done_q <= 1'b0;
      byte_done_q <= 1'b0;
      if (sample_pulse) begin
        if (phase == PH_CTRL) begin
          ctrl_sr[bit_cnt] <= mosi_s;
          if (bit_cnt == CTRL_LAST) begin
            bit_cnt     <= '0;
            phase       <= PH_DATA;
            ctrl_done_q <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else begin
          data_sr[bit_cnt[DCNT_W-1:0]] <= mosi_s;
          if (bit_cnt == DATA_LAST) begin
            bit_cnt     <= '0;
            byte_done_q <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_stb    <= 1'b0;
      wr_stb    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      addr_q    <= '0;
      is_read   <= 1'b0;
      is_burst  <= 1'b0;
      got_byte  <= 1'b0;
    end else begin
      rd_stb <= 1'b0;
      wr_stb <= 1'b0;
      if (cs_act && ctrl_done_q) begin
        is_read  <= ctrl_sr[0];
        is_burst <= ctrl_sr[CTRL_W-1];
        got_byte <= 1'b0;
        addr_q   <= field_dec[ADDR_W-1:0];
        reg_addr <= field_dec[ADDR_W-1:0];
        rd_stb   <= ctrl_sr[0];
      end else if (cs_act && byte_done_q) begin
        got_byte <= 1'b1;
        if (!is_read && (is_burst || !got_byte)) begin
          wr_stb    <= 1'b1;
          reg_addr  <= addr_q;
          reg_wdata <= data_dec;
        end
        if (is_burst) begin
          addr_q <= addr_q + 1'b1;
          if (is_read) begin
            rd_stb   <= 1'b1;
            reg_addr <= addr_q + 1'b1;
          end
        end
      end
    end
  end

  assign data_cnt   = bit_cnt[DCNT_W-1:0];
  assign data_phase = (phase == PH_DATA);
  assign byte_end   = byte_done_q;

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (!rd_stb && !wr_stb));
  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);
  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  p_data_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA) |-> (bit_cnt <= DATA_LAST));
endmodule

// File: rtl/spi_miso_drv.sv
module spi_miso_drv #(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_act,
  input  logic                      rd_stb,
  input  logic [DATA_W-1:0]         rdata,
  input  logic                      byte_end,
  input  logic [$clog2(DATA_W)-1:0] data_cnt,
  input  logic                      data_phase,
  input  logic                      swap,
  output logic                      miso_d
);
  localparam int DCNT_W = $clog2(DATA_W);
  localparam logic [DCNT_W-1:0] TOP_IDX = DCNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_q;
  logic [DCNT_W-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (!cs_act || byte_end) begin
      tx_q <= '0;
    end else if (rd_stb) begin
      tx_q <= rdata;
    end
  end

  assign sel    = swap ? (TOP_IDX - data_cnt) : data_cnt;
  assign miso_d = data_phase ? tx_q[sel] : 1'b0;

  // R8: no stale read data survives a released chip select
  p_tx_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (miso_d == 1'b0));
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_swap,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              reg_rd_stb,
  output logic              reg_wr_stb,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int DCNT_W = $clog2(DATA_W);

  logic sample_pulse, mosi_s, cs_act, data_phase, byte_end;
  logic [DCNT_W-1:0] data_cnt;

  spi_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .cs_n(spi_cs_n), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .sample_pulse(sample_pulse), .mosi_s(mosi_s), .cs_act(cs_act)
  );

  spi_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sample_pulse(sample_pulse), .mosi_s(mosi_s),
    .cs_act(cs_act), .swap(cfg_swap), .rd_stb(reg_rd_stb), .wr_stb(reg_wr_stb),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .data_cnt(data_cnt),
    .data_phase(data_phase), .byte_end(byte_end)
  );

  spi_miso_drv #(.DATA_W(DATA_W)) u_miso (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rd_stb(reg_rd_stb),
    .rdata(reg_rdata), .byte_end(byte_end), .data_cnt(data_cnt),
    .data_phase(data_phase), .swap(cfg_swap), .miso_d(spi_miso)
  );

  assign spi_miso_oe = ~spi_cs_n & cs_act;

  // R9: the pad is released while chip select is high
  p_oe_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !spi_miso_oe);
endmodule

// File: tb/spi_reg_slave_bench.sv
module spi_reg_slave_bench;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, swap = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, rd_stb, wr_stb;
  logic [12:0] addr;
  logic [7:0]  wdata, rdata;

  int checks = 0, errors = 0;
  int wr_n = 0, rd_n = 0, bad_n = 0, cs_hi = 0;
  logic [12:0] wr_addr_log [16];
  logic [7:0]  wr_data_log [16];
  logic [7:0]  tx_bytes [8];
  logic [7:0]  rx_bytes [8];

  always #5 clk = ~clk;

  spi_reg_slave u_spi_reg_slave (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_swap(swap),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
    .spi_miso_oe(miso_oe), .reg_rd_stb(rd_stb), .reg_wr_stb(wr_stb),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata)
  );

  function automatic logic [7:0] rfun(logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101} ^ 8'h3C;
  endfunction

  assign rdata = rfun(addr);

  always @(posedge clk) begin
    cs_hi <= cs_n ? cs_hi + 1 : 0;
    if (rd_stb && wr_stb) bad_n <= bad_n + 1;
    if ((rd_stb || wr_stb) && cs_hi > 2) bad_n <= bad_n + 1;
    if (wr_stb && wr_n < 16) begin
      wr_addr_log[wr_n] <= addr;
      wr_data_log[wr_n] <= wdata;
    end
    if (wr_stb) wr_n <= wr_n + 1;
    if (rd_stb) rd_n <= rd_n + 1;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mk_ctrl(logic rw, logic b, logic [12:0] a,
                                          logic res, logic sw);
    logic [13:0] f;
    logic [15:0] v;
    f = {res, a};
    v[0] = rw;
    v[15] = b;
    for (int i = 0; i < 14; i++) v[1+i] = sw ? f[13-i] : f[i];
    return v;
  endfunction

  task automatic slot(input logic b, output logic r);
    if (!cpha) begin
      mosi = b; tick(HALF);
      sclk = ~cpol; r = miso; tick(HALF);
      sclk = cpol;
    end else begin
      sclk = ~cpol; mosi = b; tick(HALF);
      sclk = cpol; r = miso; tick(HALF);
    end
  endtask

  task automatic set_mode(logic pol, logic pha, logic sw);
    cpol = pol; cpha = pha; swap = sw; sclk = pol;
    tick(4);
  endtask

  task automatic xfer(logic rw, logic b, logic [12:0] a, logic res, int nbytes,
                      int cut_bits);
    logic [15:0] cw;
    logic r;
    wr_n = 0; rd_n = 0;
    cw = mk_ctrl(rw, b, a, res, swap);
    cs_n = 1'b0; tick(6);
    for (int k = 0; k < 16; k++) slot(cw[k], r);
    for (int j = 0; j < nbytes; j++) begin
      rx_bytes[j] = 8'h00;
      for (int k = 0; k < 8; k++) begin
        if (cut_bits >= 0 && k == cut_bits) break;
        slot(swap ? tx_bytes[j][7-k] : tx_bytes[j][k], r);
        if (swap) rx_bytes[j][7-k] = r; else rx_bytes[j][k] = r;
      end
    end
    tick(6);
    cs_n = 1'b1;
    tick(6);
  endtask

  task automatic verify(string tag, logic rw, logic b, logic [12:0] a, int nbytes);
    if (!rw) begin
      int n_exp;
      n_exp = b ? nbytes : 1;
      chk({tag, " R5 write count"}, wr_n, n_exp);
      chk({tag, " R6 no read on write"}, rd_n, 0);
      for (int j = 0; j < n_exp; j++) begin
        chk({tag, " R7 write addr"}, wr_addr_log[j], 13'(a + j));
        chk({tag, " R5 write data"}, wr_data_log[j], tx_bytes[j]);
      end
    end else begin
      chk({tag, " R6 read count"}, rd_n, b ? nbytes + 1 : 1);
      chk({tag, " R5 no write on read"}, wr_n, 0);
      for (int j = 0; j < nbytes; j++)
        chk({tag, " R2 read byte"}, rx_bytes[j],
            (b || j == 0) ? rfun(13'(a + j)) : 8'h00);
    end
  endtask

  task automatic fill(int n);
    for (int j = 0; j < n; j++) tx_bytes[j] = 8'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk("R11 oe after reset", miso_oe, 0);
    chk("R11 strobes after reset", {rd_stb, wr_stb}, 0);

    // R1 R2 R3: every mode with both orders, burst write then burst read
    for (int m = 0; m < 8; m++) begin
      set_mode(m[0], m[1], m[2]);
      fill(3);
      xfer(1'b0, 1'b1, 13'h0A5 + 13'(m * 37), 1'b0, 3, -1);
      verify("R1", 1'b0, 1'b1, 13'h0A5 + 13'(m * 37), 3);
      xfer(1'b1, 1'b1, 13'h1234 - 13'(m * 91), 1'b0, 3, -1);
      verify("R2", 1'b1, 1'b1, 13'h1234 - 13'(m * 91), 3);
    end

    // R3: asymmetric address in MSB-first order
    set_mode(1'b0, 1'b0, 1'b1);
    tx_bytes[0] = 8'h01;
    xfer(1'b0, 1'b0, 13'h0001, 1'b0, 1, -1);
    verify("R3", 1'b0, 1'b0, 13'h0001, 1);

    // R4: reserved bit set does not alter the access
    set_mode(1'b1, 1'b0, 1'b0);
    tx_bytes[0] = 8'hC3;
    xfer(1'b0, 1'b0, 13'h0F0F, 1'b1, 1, -1);
    verify("R4", 1'b0, 1'b0, 13'h0F0F, 1);

    // R7: burst wraps from the top address
    set_mode(1'b0, 1'b1, 1'b1);
    xfer(1'b1, 1'b1, 13'h1FFF, 1'b0, 3, -1);
    verify("R7", 1'b1, 1'b1, 13'h1FFF, 3);
    fill(2);
    xfer(1'b0, 1'b1, 13'h1FFF, 1'b0, 2, -1);
    verify("R7", 1'b0, 1'b1, 13'h1FFF, 2);

    // R8: bytes past the first without burst
    set_mode(1'b1, 1'b1, 1'b0);
    xfer(1'b1, 1'b0, 13'h0777, 1'b0, 3, -1);
    verify("R8", 1'b1, 1'b0, 13'h0777, 3);
    fill(2);
    xfer(1'b0, 1'b0, 13'h0100, 1'b0, 2, -1);
    verify("R8", 1'b0, 1'b0, 13'h0100, 2);

    // R9: transaction cut mid-byte, then a clean one
    chk("R9 oe while cs high", miso_oe, 0);
    fill(1);
    xfer(1'b0, 1'b0, 13'h0222, 1'b0, 1, 3);
    chk("R9 no write after cut", wr_n, 0);
    fill(1);
    xfer(1'b0, 1'b0, 13'h0333, 1'b0, 1, -1);
    verify("R9", 1'b0, 1'b0, 13'h0333, 1);
    cs_n = 1'b0; tick(6);
    chk("R9 oe while selected", miso_oe, 1);
    cs_n = 1'b1; tick(6);

    // random traffic across modes
    for (int t = 0; t < 30; t++) begin
      logic rw, b;
      logic [12:0] a;
      int n;
      set_mode(1'($urandom), 1'($urandom), 1'($urandom));
      rw = 1'($urandom);
      b  = 1'($urandom);
      a  = 13'($urandom);
      n  = 1 + int'($urandom % 4);
      fill(n);
      xfer(rw, b, a, 1'($urandom), n, -1);
      verify("R3 random", rw, b, a, n);
    end

    chk("R10 strobe overlap or idle strobe", bad_n, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule